// File: doc/BRIEF.md
# Flash Program/Erase Completion Poller

After a controller has issued a program or erase command to a parallel NOR-style flash, this block works out whether the operation finished well. It takes a one-cycle start pulse together with a poll address, the byte that was written and a method select. It then issues single-byte reads on a request/acknowledge memory port until it can reach a verdict. The verdict is reported as a one-cycle done pulse with a pass flag.

Two methods are built in. The first is bit-7 data polling: bit 7 of the read byte is compared with bit 7 of the written byte. The second is toggle detection: bit 6 is compared across a pair of back-to-back reads. In both methods, the error flags (bits 5 and 3) never cause an immediate fail. The block first takes a confirming read, or a confirming pair of reads, because the status bit can settle in the same cycle as the flags rise. On a fail it asks an external command sequencer to send the exit sequence that returns the flash to read mode. It reports done only once that request has been acknowledged. A poll budget bounds the number of reads per operation.

The caller chooses the address. For a program it is the programmed location. For a sector erase it is any location in that sector. For a chip erase it is any location in an unprotected sector.

Top module: `flash_done_poller`

## Requirements
- R1: After reset the block is idle: busy_o, rd_req_o, exit_req_o and done_o are all 0.
- R2: A start_i pulse while idle makes busy_o 1 and starts reads at the address given with the start. rd_req_o stays 1 and rd_addr_o stays unchanged until rd_ack_i, and each cycle with rd_ack_i high delivers one byte on rd_data_i.
- R3: With mode_i = 2'b00, a read whose bit 7 equals bit 7 of expect_i ends the operation with pass.
- R4: In bit-7 mode, a read whose bit 7 differs while bits 5 and 3 are both 0 is followed by another read.
- R5: In bit-7 mode, a differing read with bit 5 or bit 3 set is followed by exactly one more read. If that read's bit 7 matches, the result is pass; otherwise it is fail.
- R6: With mode_i = 2'b01, reads are taken in pairs. If bit 6 is equal in both reads of a pair, the result is pass. If it differs and bits 5 and 3 of the second read are both 0, a fresh pair is read.
- R7: In toggle mode, if bit 6 differs in a pair and the second read has bit 5 or bit 3 set, one more pair is read. If bit 6 is stable in that pair, the result is pass; if it still toggles, the result is fail.
- R8: On a fail, exit_req_o rises and is held until exit_ack_i. done_o with pass_o = 0 follows only after that acknowledge. A pass never raises exit_req_o.
- R9: done_o is a single-cycle pulse, and pass_o is valid in that cycle. On a pass, done_o comes in the cycle after the deciding read's acknowledge.
- R10: start_i while busy is ignored: the address, method and result of the running operation are unchanged.
- R11: If MAX_POLLS reads give no verdict, the operation fails on the MAX_POLLS-th read.
- R12: mode_i values 2'b10 and 2'b11 behave as bit-7 mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, taken only when idle |
| addr_i | input | ADDR_W | Poll address, captured at start |
| expect_i | input | 8 | Byte that was written, captured at start |
| mode_i | input | 2 | 00 bit-7 polling, 01 toggle, others bit-7 |
| busy_o | output | 1 | Operation in progress |
| rd_req_o | output | 1 | Byte read request |
| rd_addr_o | output | ADDR_W | Read address |
| rd_ack_i | input | 1 | Read acknowledge; data valid in this cycle |
| rd_data_i | input | 8 | Read data |
| exit_req_o | output | 1 | Request for the return-to-read-mode sequence |
| exit_ack_i | input | 1 | Sequencer has sent the exit sequence |
| done_o | output | 1 | One-cycle completion pulse |
| pass_o | output | 1 | Verdict, valid with done_o |

## Verification
The assertions assume that rd_ack_i is high only in cycles where rd_req_o is high, and that exit_ack_i is high only while exit_req_o is high. Under those assumptions, holding the request, the fail-via-exit order and the single-cycle done can be stated directly at the ports. The bench's memory responder therefore acknowledges only a request it observed on the preceding falling edge, with a varying wait. The exit responder behaves the same way. The start inputs are driven between edges, and the bench pulses start during a running operation only to check that it is ignored.

// File: rtl/fpoll_pkg.sv
package fpoll_pkg;
    // Status byte bit positions used by the flash during an operation
    localparam int DPOLL_BIT  = 7;
    localparam int TOGGLE_BIT = 6;
    localparam int TMO_BIT    = 5;
    localparam int SUSP_BIT   = 3;

    localparam logic [1:0] MODE_TOGGLE = 2'b01;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_READ = 2'd1,
        ST_EXIT = 2'd2
    } state_e;

    typedef enum logic [1:0] {
        V_MORE = 2'd0,
        V_PASS = 2'd1,
        V_FAIL = 2'd2
    } verdict_e;

    typedef struct packed {
        verdict_e verdict;
        logic     recheck;
        logic     have_prev;
    } judge_t;
endpackage

// File: rtl/fpoll_judge.sv
module fpoll_judge
    import fpoll_pkg::*;
(
    input  logic       tog_mode_i,
    input  logic       recheck_i,
    input  logic       have_prev_i,
    input  logic       prev_tog_i,
    input  logic       want7_i,
    input  logic [7:0] rdata_i,
    output judge_t     judge_o
);
    logic flag;

    always_comb begin
        flag              = rdata_i[TMO_BIT] | rdata_i[SUSP_BIT];
        judge_o.verdict   = V_MORE;
        judge_o.recheck   = recheck_i;
        judge_o.have_prev = have_prev_i;
        if (!tog_mode_i) begin
            if (rdata_i[DPOLL_BIT] == want7_i) begin
                judge_o.verdict = V_PASS;
            end else if (recheck_i) begin
                judge_o.verdict = V_FAIL;
            end else if (flag) begin
                judge_o.recheck = 1'b1;
            end
        end else if (!have_prev_i) begin
            judge_o.have_prev = 1'b1;
        end else begin
            judge_o.have_prev = 1'b0;
            if (rdata_i[TOGGLE_BIT] == prev_tog_i) begin
                judge_o.verdict = V_PASS;
            end else if (recheck_i) begin
                judge_o.verdict = V_FAIL;
            end else if (flag) begin
                judge_o.recheck = 1'b1;
            end
        end
    end
endmodule

// File: rtl/fpoll_budget.sv
module fpoll_budget #(
    parameter int LIMIT = 4096
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic clear_i,
    input  logic step_i,
    output logic last_o
);
    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clear_i) begin
            cnt_d = '0;
        end else if (step_i) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end

    // High while the read now in flight is the last one allowed
    assign last_o = (cnt_q == CW'(LIMIT - 1));
endmodule

// File: rtl/flash_done_poller.sv
module flash_done_poller
    import fpoll_pkg::*;
#(
    parameter int ADDR_W    = 24,
    parameter int MAX_POLLS = 4096
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [7:0]        expect_i,
    input  logic [1:0]        mode_i,
    output logic              busy_o,
    output logic              rd_req_o,
    output logic [ADDR_W-1:0] rd_addr_o,
    input  logic              rd_ack_i,
    input  logic [7:0]        rd_data_i,
    output logic              exit_req_o,
    input  logic              exit_ack_i,
    output logic              done_o,
    output logic              pass_o
);
    typedef struct packed {
        state_e            state;
        logic [ADDR_W-1:0] addr;
        logic              want7;
        logic              tog_mode;
        logic              recheck;
        logic              have_prev;
        logic              prev6;
        logic              done;
        logic              pass;
    } regs_t;

    regs_t  r_d, r_q;
    judge_t jv;
    logic   take_start;
    logic   read_fire;
    logic   budget_last;

    assign take_start = (r_q.state == ST_IDLE) && start_i;
    assign read_fire  = (r_q.state == ST_READ) && rd_ack_i;

    fpoll_judge u_judge (
        .tog_mode_i  (r_q.tog_mode),
        .recheck_i   (r_q.recheck),
        .have_prev_i (r_q.have_prev),
        .prev_tog_i  (r_q.prev6),
        .want7_i     (r_q.want7),
        .rdata_i     (rd_data_i),
        .judge_o     (jv)
    );

    fpoll_budget #(.LIMIT(MAX_POLLS)) u_budget (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .clear_i (take_start),
        .step_i  (read_fire),
        .last_o  (budget_last)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        unique case (r_q.state)
            ST_IDLE: begin
                if (start_i) begin
                    r_d.state     = ST_READ;
                    r_d.addr      = addr_i;
                    r_d.want7     = expect_i[DPOLL_BIT];
                    r_d.tog_mode  = (mode_i == MODE_TOGGLE);
                    r_d.recheck   = 1'b0;
                    r_d.have_prev = 1'b0;
                    r_d.pass      = 1'b0;
                end
            end
            ST_READ: begin
                if (rd_ack_i) begin
                    r_d.recheck   = jv.recheck;
                    r_d.have_prev = jv.have_prev;
                    r_d.prev6     = rd_data_i[TOGGLE_BIT];
                    if (jv.verdict == V_PASS) begin
                        r_d.state = ST_IDLE;
                        r_d.done  = 1'b1;
                        r_d.pass  = 1'b1;
                    end else if (jv.verdict == V_FAIL || budget_last) begin
                        r_d.state = ST_EXIT;
                        r_d.pass  = 1'b0;
                    end
                end
            end
            ST_EXIT: begin
                if (exit_ack_i) begin
                    r_d.state = ST_IDLE;
                    r_d.done  = 1'b1;
                    r_d.pass  = 1'b0;
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            r_q       <= '0;
            r_q.state <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy_o     = (r_q.state != ST_IDLE);
    assign rd_req_o   = (r_q.state == ST_READ);
    assign rd_addr_o  = r_q.addr;
    assign exit_req_o = (r_q.state == ST_EXIT);
    assign done_o     = r_q.done;
    assign pass_o     = r_q.pass;
endmodule

// File: rtl/fpoll_checker.sv
module fpoll_checker #(
    parameter int ADDR_W = 24
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              start_i,
    input logic              busy_o,
    input logic              rd_req_o,
    input logic [ADDR_W-1:0] rd_addr_o,
    input logic              rd_ack_i,
    input logic              exit_req_o,
    input logic              exit_ack_i,
    input logic              done_o,
    input logic              pass_o
);
    p_idle_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !busy_o |-> (!rd_req_o && !exit_req_o));

    p_req_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_req_o && !rd_ack_i) |=> (rd_req_o && $stable(rd_addr_o)));

    p_exit_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (exit_req_o && !exit_ack_i) |=> exit_req_o);

    p_fail_via_exit_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (done_o && !pass_o) |-> $past(exit_req_o && exit_ack_i));

    p_one_request_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(rd_req_o && exit_req_o));

    p_pass_after_read_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (done_o && pass_o) |-> $past(rd_req_o && rd_ack_i));

    p_done_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o);

    p_busy_start_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy_o && start_i) |=> $stable(rd_addr_o));
endmodule

bind flash_done_poller fpoll_checker #(.ADDR_W(ADDR_W)) u_fpoll_checker (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .busy_o     (busy_o),
    .rd_req_o   (rd_req_o),
    .rd_addr_o  (rd_addr_o),
    .rd_ack_i   (rd_ack_i),
    .exit_req_o (exit_req_o),
    .exit_ack_i (exit_ack_i),
    .done_o     (done_o),
    .pass_o     (pass_o)
);

// File: tb/flash_done_poller_bench.sv
module flash_done_poller_bench;
    localparam int ADDR_W = 16;
    localparam int MAXP   = 16;

    typedef logic [7:0] bq_t[$];

    logic              clk_i = 1'b0;
    logic              rst_ni = 1'b0;
    logic              start_i = 1'b0;
    logic [ADDR_W-1:0] addr_i = '0;
    logic [7:0]        expect_i = '0;
    logic [1:0]        mode_i = '0;
    logic              busy_o, rd_req_o, exit_req_o, done_o, pass_o;
    logic [ADDR_W-1:0] rd_addr_o;
    logic              rd_ack_i = 1'b0;
    logic [7:0]        rd_data_i = '0;
    logic              exit_ack_i = 1'b0;

    int checks = 0;
    int errors = 0;

    always #4 clk_i = ~clk_i;

    flash_done_poller #(.ADDR_W(ADDR_W), .MAX_POLLS(MAXP)) u_flash_done_poller (
        .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .addr_i(addr_i),
        .expect_i(expect_i), .mode_i(mode_i), .busy_o(busy_o), .rd_req_o(rd_req_o),
        .rd_addr_o(rd_addr_o), .rd_ack_i(rd_ack_i), .rd_data_i(rd_data_i),
        .exit_req_o(exit_req_o), .exit_ack_i(exit_ack_i), .done_o(done_o), .pass_o(pass_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // Reference: verdict and number of reads from the byte stream
    function automatic void predict(input logic [1:0] m, input logic [7:0] e, input bq_t b,
                                    output bit ok, output int n);
        bit tog = (m == 2'b01);
        bit rc = 0;
        bit hp = 0;
        logic [7:0] pv = '0;
        logic [7:0] v;
        ok = 0;
        n  = 0;
        while (n < 1000) begin
            v = (n < b.size()) ? b[n] : 8'h00;
            n++;
            if (!tog) begin
                if (v[7] == e[7]) begin ok = 1; return; end
                if (rc) return;
                if (v[5] || v[3]) rc = 1;
            end else if (!hp) begin
                pv = v;
                hp = 1;
            end else begin
                hp = 0;
                if (v[6] == pv[6]) begin ok = 1; return; end
                if (rc) return;
                if (v[5] || v[3]) rc = 1;
            end
            if (n == MAXP) return;
        end
    endfunction

    task automatic run_case(input string tag, input logic [1:0] m, input logic [7:0] e,
                            input logic [ADDR_W-1:0] a, input bq_t b, input bit poke);
        bit exp_ok;
        int exp_n;
        int n = 0;
        int cyc = 0;
        int wait_rd = 0;
        int wait_ex = 2;
        int bad_addr = 0;
        bit saw_exit = 0;
        bit got_done = 0;
        bit got_pass = 0;
        predict(m, e, b, exp_ok, exp_n);
        @(negedge clk_i);
        start_i = 1'b1; mode_i = m; expect_i = e; addr_i = a;
        @(negedge clk_i);
        start_i = 1'b0;
        check(busy_o == 1'b1, {tag, " R2 busy"}, busy_o, 1);
        while (!got_done && cyc < 2000) begin
            rd_ack_i   = 1'b0;
            exit_ack_i = 1'b0;
            if (poke) begin
                start_i = (cyc == 1);
                addr_i  = ~a;
                mode_i  = ~m;
                expect_i = ~e;
            end
            if (done_o) begin
                got_done = 1;
                got_pass = pass_o;
            end else begin
                if (rd_req_o) begin
                    if (rd_addr_o != a) bad_addr++;
                    if (wait_rd == 0) begin
                        rd_ack_i  = 1'b1;
                        rd_data_i = (n < b.size()) ? b[n] : 8'h00;
                        n++;
                        wait_rd = n % 3;
                    end else begin
                        wait_rd--;
                    end
                end
                if (exit_req_o) begin
                    saw_exit = 1;
                    if (wait_ex == 0) exit_ack_i = 1'b1;
                    else wait_ex--;
                end
                @(negedge clk_i);
                cyc++;
            end
        end
        start_i = 1'b0;
        check(got_done, {tag, " R9 done seen"}, got_done, 1);
        check(got_pass == exp_ok, {tag, " verdict"}, got_pass, exp_ok);
        check(n == exp_n, {tag, " read count"}, n, exp_n);
        check(saw_exit == !exp_ok, {tag, " R8 exit request"}, saw_exit, !exp_ok);
        check(bad_addr == 0, {tag, " R2 address"}, bad_addr, 0);
        @(negedge clk_i);
        check(!done_o && !busy_o, {tag, " R9 single pulse"}, done_o, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk_i);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk_i);
        check(!busy_o && !rd_req_o && !exit_req_o && !done_o, "R1 reset idle", busy_o, 0);
        rst_ni = 1'b1;
        @(negedge clk_i);
        check(!busy_o && !rd_req_o && !exit_req_o && !done_o, "R1 after release", busy_o, 0);

        run_case("R3 immediate match", 2'b00, 8'h80, 16'h1234, '{8'h80}, 0);
        run_case("R4 poll until match", 2'b00, 8'hA5, 16'h0010, '{8'h00, 8'h01, 8'h40, 8'h80}, 0);
        run_case("R5 flag then match", 2'b00, 8'h80, 16'h0020, '{8'h20, 8'h80}, 0);
        run_case("R5 flag then mismatch", 2'b00, 8'h80, 16'h0030, '{8'h08, 8'h00}, 0);
        run_case("R6 stable pair", 2'b01, 8'h00, 16'h0040, '{8'h40, 8'h40}, 0);
        run_case("R6 toggling pairs", 2'b01, 8'h00, 16'h0050,
                 '{8'h00, 8'h40, 8'h00, 8'h40, 8'h40, 8'h40}, 0);
        run_case("R7 flag then stable", 2'b01, 8'h00, 16'h0060, '{8'h00, 8'h60, 8'h20, 8'h20}, 0);
        run_case("R7 flag then toggle", 2'b01, 8'h00, 16'h0070, '{8'h00, 8'h48, 8'h00, 8'h40}, 0);
        run_case("R11 budget", 2'b00, 8'h80, 16'h0080, '{8'h00, 8'h00, 8'h00}, 0);
        run_case("R12 mode 10", 2'b10, 8'h00, 16'h0090, '{8'h00, 8'h40}, 0);
        run_case("R12 mode 11", 2'b11, 8'h80, 16'h00A0, '{8'h00, 8'h80}, 0);
        run_case("R10 start while busy", 2'b00, 8'h80, 16'h00B0,
                 '{8'h00, 8'h00, 8'h00, 8'h80}, 1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule